// File: doc/BRIEF.md
# Sample-Rate to PLL Divider Encoder

This block turns a requested audio sample rate, given in hertz, into the 12-bit control word of a clock synthesiser that runs from a 28.224 MHz reference. It also reports the sample rate that the synthesiser will actually produce. A caller presents a 32-bit rate with a one-cycle request strobe. Some cycles later the block returns a completion pulse. With that pulse come the control word, already split into a 4-bit upper register value and an 8-bit lower register value, the achieved rate, and an error flag.

The encoder first divides twice the reference frequency by the requested rate. It halves that quotient minus one to get a raw divider. The raw divider then falls into one of five ranges. Each range sets a prefix in the upper bits of the word, and the two largest ranges also drop one or two low bits of the divider. Once the dropped bits are cleared, the reference is divided by the adjusted divider plus one, which gives the achieved rate. One sequential restoring divider handles both divisions in turn. A request that arrives while a conversion is running is dropped.

Top module: `srate_pll_enc`

## Requirements
- R1: A request whose rate is below 6900 or above 219000 is answered on the next cycle with done and err set and with the upper value, lower value and achieved rate all zero. Both limits themselves are accepted.
- R2: For an accepted rate f, the raw divider is floor((floor(56448000 / f) - 1) / 2).
- R3: A raw divider below 0x100 gives the word raw + 0xC00.
- R4: A raw divider from 0x100 to 0x1FF gives the word raw + 0x800.
- R5: A raw divider from 0x200 to 0x3FF gives the word raw AND 0x1FF, with no prefix.
- R6: A raw divider from 0x400 to 0x7FF gives the word ((raw >> 1) AND 0x1FF) + 0x200, and the adjusted divider is raw with bit 0 cleared.
- R7: A larger raw divider gives the word ((raw >> 2) AND 0x1FF) + 0x400, and the adjusted divider is raw with bits 1:0 cleared. In all other ranges the adjusted divider equals raw.
- R8: The achieved rate is floor(28224000 / (adjusted divider + 1)), and err is low.
- R9: The upper output carries word bits 11:8 and the lower output carries word bits 7:0.
- R10: For an accepted in-range rate, done is high for exactly one cycle, 54 clock edges after the edge that took the request.
- R11: A request made while a conversion is running is ignored. It neither alters the result nor raises an extra done. A request is taken again from the edge after done.
- R12: After reset, done, err and all data outputs are zero. Between completions every output keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, sampled when idle |
| req_hz_i | input | 32 | Requested sample rate in hertz |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Rate out of the accepted band |
| pll_hi_o | output | 4 | Control word bits 11:8 |
| pll_lo_o | output | 8 | Control word bits 7:0 |
| achieved_hz_o | output | 32 | Rate produced by the encoded divider |

## Verification
The bench aims at rates whose raw divider lands exactly on each range edge: 0xFF/0x100, 0x1FF/0x200, 0x3FF/0x400 and 0x7FF/0x800. A comparison off by one there would pick the wrong prefix and skip the bit truncation, so both the word and the achieved rate would be wrong. Rates one hertz either side of 6900 and 219000 catch a band check that uses the wrong inclusive or exclusive edge. Zero and all-ones inputs would otherwise make the divider run on a bad divisor. A request held high through a whole conversion exposes a design that restarts, or that reports twice, when it should ignore the new input. A held out-of-band request checks that rejection answers every cycle.

// File: rtl/srate_pll_pkg.sv
package srate_pll_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_DIV_RAW = 2'd1,
      ST_DIV_ACH = 2'd2
   } enc_state_t;

   localparam int unsigned CTRL_W = 12;
   localparam int unsigned HI_W   = 4;
   localparam int unsigned LO_W   = 8;

   // range edges of the raw divider; order sets the prefix priority
   localparam int unsigned EDGE_A = 32'h100;
   localparam int unsigned EDGE_B = 32'h200;
   localparam int unsigned EDGE_C = 32'h400;
   localparam int unsigned EDGE_D = 32'h800;

endpackage

// File: rtl/srate_restoring_div.sv
module srate_restoring_div
   import srate_pll_pkg::*;
#(
   parameter int unsigned NUM_W = 26,
   parameter int unsigned DEN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [NUM_W-1:0] quo_o
);

   localparam int unsigned CNT_W = $clog2(NUM_W + 1);

   generate
      if (NUM_W < 2) begin : g_bad_num
         $error("srate_restoring_div: NUM_W must be at least 2");
      end
      if (DEN_W < 1) begin : g_bad_den
         $error("srate_restoring_div: DEN_W must be positive");
      end
   endgenerate

   logic [DEN_W:0]   rem_q;
   logic [NUM_W-1:0] acc_q;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] cnt_q;

   logic [DEN_W:0]   shifted;
   logic [DEN_W:0]   diff;
   logic             fits;

   always_comb begin
      shifted = {rem_q[DEN_W-1:0], acc_q[NUM_W-1]};
      fits    = (shifted >= {1'b0, den_q});
      diff    = shifted - {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         acc_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else if (start_i) begin
         rem_q  <= '0;
         acc_q  <= num_i;
         den_q  <= den_i;
         cnt_q  <= CNT_W'(NUM_W);
         done_o <= 1'b0;
      end else if (cnt_q != '0) begin
         rem_q  <= fits ? diff : shifted;
         acc_q  <= {acc_q[NUM_W-2:0], fits};
         cnt_q  <= cnt_q - CNT_W'(1);
         done_o <= (cnt_q == CNT_W'(1));
      end else begin
         done_o <= 1'b0;
      end
   end

   assign busy_o = (cnt_q != '0);
   assign quo_o  = acc_q;

   AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (rem_q < {1'b0, den_q})); // R2

   AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R10

endmodule

// File: rtl/srate_range_pack.sv
module srate_range_pack
   import srate_pll_pkg::*;
#(
   parameter int unsigned RAW_W = 12
) (
   input  logic [RAW_W-1:0]  raw_i,
   output logic [CTRL_W-1:0] word_o,
   output logic [RAW_W-1:0]  adj_o
);

   generate
      if (RAW_W < 12) begin : g_bad_raw
         $error("srate_range_pack: RAW_W must be at least 12");
      end
   endgenerate

   always_comb begin
      if (raw_i < RAW_W'(EDGE_A)) begin
         // R3: fastest range, prefix 0b11
         word_o = {4'hC, raw_i[7:0]};
         adj_o  = raw_i;
      end else if (raw_i < RAW_W'(EDGE_B)) begin
         // R4: prefix 0b10 over nine divider bits
         word_o = 12'h800 + {3'b000, raw_i[8:0]};
         adj_o  = raw_i;
      end else if (raw_i < RAW_W'(EDGE_C)) begin
         // R5: nine bits, no prefix
         word_o = {3'b000, raw_i[8:0]};
         adj_o  = raw_i;
      end else if (raw_i < RAW_W'(EDGE_D)) begin
         // R6: post-divide by two, bit 0 lost
         word_o = 12'h200 + {3'b000, raw_i[9:1]};
         adj_o  = {raw_i[RAW_W-1:1], 1'b0};
      end else begin
         // R7: post-divide by four, bits 1:0 lost
         word_o = 12'h400 + {3'b000, raw_i[10:2]};
         adj_o  = {raw_i[RAW_W-1:2], 2'b00};
      end
   end

endmodule

// File: rtl/srate_pll_enc.sv
module srate_pll_enc
   import srate_pll_pkg::*;
#(
   parameter int unsigned FREQ_W = 32,
   parameter int unsigned REF_HZ = 28224000,
   parameter int unsigned MIN_HZ = 6900,
   parameter int unsigned MAX_HZ = 219000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [FREQ_W-1:0] req_hz_i,
   output logic              done_o,
   output logic              err_o,
   output logic [HI_W-1:0]   pll_hi_o,
   output logic [LO_W-1:0]   pll_lo_o,
   output logic [FREQ_W-1:0] achieved_hz_o
);

   localparam int unsigned NUM_W = $clog2(2 * REF_HZ + 1);
   localparam int unsigned RAW_W = $clog2(REF_HZ / MIN_HZ + 1);

   generate
      if (MIN_HZ == 0 || MAX_HZ < MIN_HZ) begin : g_bad_band
         $error("srate_pll_enc: rate band is empty");
      end
      if (FREQ_W < NUM_W) begin : g_bad_freq_w
         $error("srate_pll_enc: FREQ_W too narrow for the quotient");
      end
      if (RAW_W < 12) begin : g_bad_raw_w
         $error("srate_pll_enc: MIN_HZ too high for the range encoding");
      end
   endgenerate

   enc_state_t        state_q;
   logic [CTRL_W-1:0] word_q;

   logic              in_band;
   logic              accept;
   logic              div_start;
   logic [NUM_W-1:0]  div_num;
   logic [FREQ_W-1:0] div_den;
   logic              div_busy;
   logic              div_done;
   logic [NUM_W-1:0]  div_quo;
   logic [RAW_W-1:0]  raw;
   logic [CTRL_W-1:0] pk_word;
   logic [RAW_W-1:0]  pk_adj;

   always_comb begin
      in_band   = (req_hz_i >= FREQ_W'(MIN_HZ)) && (req_hz_i <= FREQ_W'(MAX_HZ));
      accept    = (state_q == ST_IDLE) && req_valid_i;
      raw       = RAW_W'((div_quo - NUM_W'(1)) >> 1);
      div_start = (accept && in_band) || ((state_q == ST_DIV_RAW) && div_done);
      div_num   = (state_q == ST_IDLE) ? NUM_W'(2 * REF_HZ) : NUM_W'(REF_HZ);
      div_den   = (state_q == ST_IDLE) ? req_hz_i
                                       : FREQ_W'(pk_adj) + FREQ_W'(1);
   end

   srate_restoring_div #(
      .NUM_W (NUM_W),
      .DEN_W (FREQ_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (div_start),
      .num_i   (div_num),
      .den_i   (div_den),
      .busy_o  (div_busy),
      .done_o  (div_done),
      .quo_o   (div_quo)
   );

   srate_range_pack #(
      .RAW_W (RAW_W)
   ) u_pack (
      .raw_i  (raw),
      .word_o (pk_word),
      .adj_o  (pk_adj)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         word_q        <= '0;
         done_o        <= 1'b0;
         err_o         <= 1'b0;
         pll_hi_o      <= '0;
         pll_lo_o      <= '0;
         achieved_hz_o <= '0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (in_band) begin
                     state_q <= ST_DIV_RAW;
                  end else begin
                     done_o        <= 1'b1;
                     err_o         <= 1'b1;
                     pll_hi_o      <= '0;
                     pll_lo_o      <= '0;
                     achieved_hz_o <= '0;
                  end
               end
            end
            ST_DIV_RAW: begin
               if (div_done) begin
                  word_q  <= pk_word;
                  state_q <= ST_DIV_ACH;
               end
            end
            ST_DIV_ACH: begin
               if (div_done) begin
                  done_o        <= 1'b1;
                  err_o         <= 1'b0;
                  pll_hi_o      <= word_q[CTRL_W-1:LO_W];
                  pll_lo_o      <= word_q[LO_W-1:0];
                  achieved_hz_o <= FREQ_W'(div_quo);
                  state_q       <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_REJECT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (pll_hi_o == '0 && pll_lo_o == '0 && achieved_hz_o == '0)); // R1

   AST_ADJ_WITHIN_THREE: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_DIV_RAW) && div_done) |-> ((pk_adj <= raw) && ((raw - pk_adj) <= RAW_W'(3)))); // R7

   AST_ACH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (achieved_hz_o != '0)); // R8

   AST_FLIGHT_TRACKS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> (div_busy || div_done)); // R10

   AST_NO_DONE_MIDFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q != ST_IDLE) && !((state_q == ST_DIV_ACH) && div_done)) |=> !done_o); // R11

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable({err_o, pll_hi_o, pll_lo_o, achieved_hz_o})); // R12

endmodule

// File: tb/srate_pll_enc_tb.sv
`timescale 1ns/1ps
module srate_pll_enc_tb;

   localparam int LAT = 54;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_hz = '0;
   logic        done, err;
   logic [3:0]  hi;
   logic [7:0]  lo;
   logic [31:0] ach;

   int vectors = 0;
   int miscompares = 0;
   bit chk_en = 1'b0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   srate_pll_enc u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid_i   (req_valid),
      .req_hz_i      (req_hz),
      .done_o        (done),
      .err_o         (err),
      .pll_hi_o      (hi),
      .pll_lo_o      (lo),
      .achieved_hz_o (ach)
   );

   // behavioural reference
   function automatic void ref_model(input longint f, output bit e,
                                     output logic [3:0] rhi, output logic [7:0] rlo,
                                     output logic [31:0] rach, output string tag);
      longint q, raw, adj, w;
      if (f < 6900 || f > 219000) begin
         e = 1; rhi = 0; rlo = 0; rach = 0; tag = "R1";
         return;
      end
      e   = 0;
      q   = (2 * 28224000) / f;
      raw = (q - 1) / 2;
      if (raw < 'h100) begin
         w = raw + 'hC00; adj = raw; tag = "R2/R3/R8/R9";
      end else if (raw < 'h200) begin
         w = raw + 'h800; adj = raw; tag = "R2/R4/R8/R9";
      end else if (raw < 'h400) begin
         w = raw & 'h1FF; adj = raw; tag = "R2/R5/R8/R9";
      end else if (raw < 'h800) begin
         w = ((raw >> 1) & 'h1FF) + 'h200; adj = raw & ~longint'(1); tag = "R2/R6/R8/R9";
      end else begin
         w = ((raw >> 2) & 'h1FF) + 'h400; adj = raw & ~longint'(3); tag = "R2/R7/R8/R9";
      end
      rach = 32'(28224000 / (adj + 1));
      rhi  = 4'((w >> 8) & 'hF);
      rlo  = 8'(w & 'hFF);
   endfunction

   int          m_cnt;
   logic        m_done, m_err;
   logic [3:0]  m_hi, p_hi;
   logic [7:0]  m_lo, p_lo;
   logic [31:0] m_ach, p_ach;
   string       m_tag, p_tag;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_done = 0; m_err = 0; m_hi = 0; m_lo = 0; m_ach = 0; m_tag = "R12";
      end else begin
         bit          e;
         logic [3:0]  th;
         logic [7:0]  tl;
         logic [31:0] ta;
         string       tt;
         m_done = 0;
         if (m_cnt > 0) begin
            // R11: requests here are dropped
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
               m_done = 1; m_err = 0; m_hi = p_hi; m_lo = p_lo; m_ach = p_ach; m_tag = p_tag;
            end
         end else if (req_valid) begin
            ref_model(longint'(req_hz), e, th, tl, ta, tt);
            if (e) begin
               m_done = 1; m_err = 1; m_hi = 0; m_lo = 0; m_ach = 0; m_tag = tt;
            end else begin
               m_cnt = LAT; p_hi = th; p_lo = tl; p_ach = ta; p_tag = tt;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && chk_en && !finished) begin
         vectors = vectors + 1;
         if (done !== m_done) begin
            miscompares = miscompares + 1;
            $display("FAIL %s done: got %0b exp %0b (rate %0d)",
                     m_err ? "R1" : "R10", done, m_done, req_hz);
         end
         vectors = vectors + 1;
         if (err !== m_err || hi !== m_hi || lo !== m_lo || ach !== m_ach) begin
            miscompares = miscompares + 1;
            $display("FAIL %s err/hi/lo/ach: got %0b/%h/%h/%0d exp %0b/%h/%h/%0d",
                     m_done ? m_tag : "R12 hold", err, hi, lo, ach, m_err, m_hi, m_lo, m_ach);
         end
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (m_cnt != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic send(input logic [31:0] f);
      @(negedge clk);
      req_valid = 1'b1;
      req_hz    = f;
      @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         miscompares = miscompares + 1;
         $display("FAIL watchdog expired: got running exp finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      vectors = vectors + 1;
      if (done !== 0 || err !== 0 || hi !== 0 || lo !== 0 || ach !== 0) begin
         miscompares = miscompares + 1;
         $display("FAIL R12 reset: got %0b/%0b/%h/%h/%0d exp 0/0/0/0/0", done, err, hi, lo, ach);
      end
      chk_en = 1'b1;

      // R1 band edges and extreme inputs
      send(32'd6899);
      send(32'd6900);
      send(32'd219000);
      send(32'd219001);
      send(32'd0);
      send(32'hFFFF_FFFF);

      // common rates across all ranges
      send(32'd8000);  send(32'd11025); send(32'd16000); send(32'd22050);
      send(32'd32000); send(32'd44100); send(32'd48000); send(32'd64000);
      send(32'd88200); send(32'd96000); send(32'd128000); send(32'd176400);
      send(32'd192000);

      // raw divider range edges: R3/R4, R4/R5, R5/R6, R6/R7
      send(32'd110500); send(32'd110400); send(32'd110000);
      send(32'd55200);  send(32'd55100);  send(32'd55000);
      send(32'd27600);  send(32'd27560);  send(32'd27549);
      send(32'd13790);  send(32'd13780);  send(32'd13777);

      // geometric sweep
      for (int f = 6900; f <= 219000; f = f + f / 12) send(32'(f));

      // R11: request held through a conversion with a new rate
      @(negedge clk);
      req_valid = 1'b1; req_hz = 32'd48000;
      @(negedge clk);
      req_hz = 32'd8000;
      repeat (20) @(negedge clk);
      req_hz = 32'd6000;
      repeat (20) @(negedge clk);
      req_valid = 1'b0;
      wait_idle();

      // R1: out-of-band request held answers every cycle
      @(negedge clk);
      req_valid = 1'b1; req_hz = 32'd5;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      wait_idle();

      // R12: outputs hold while idle
      repeat (10) @(negedge clk);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule